// File: doc/BRIEF.md
# Cascaded Attenuator Chain Serial Programmer

This block is the host-side master that loads attenuation settings into a chain of step attenuators. The devices share one serial clock line, one latch-enable line and a serial data path: data enters the nearest device and ripples onward. A command carries one 6-bit code per device. The block turns each code into an 8-bit frame and shifts all frames out most significant bit first. It then raises latch enable once, so that every device in the chain applies its new setting on the same edge.

Commands arrive on a valid/ready handshake. `cmd_ready_o` is high only while the block is idle. A command transfers on a clock edge where both `cmd_valid_i` and `cmd_ready_o` are high. An upstream source may hold valid and codes steady until ready returns. Valid seen while ready is low has no effect and is not remembered. Ready stays low from acceptance until the spacing time after the latch pulse has run out.

All serial timing comes from the system clock through cycle-count parameters: the clock half-period, the lead/tail guard time, the latch width and the spacing after the latch. At elaboration the block checks that these counts meet the devices' minimum timings: clock period at least 70 ns, setup at least 15 ns, latch enable at least 15 ns after the last clock edge, latch pulse at least 10 ns, and at least 630 ns between latch pulses.

Top module: `atten_chain_prog`

## Requirements
- R1: Each device receives an 8-bit frame sent MSB first: two zero pad bits, then its 6-bit code from bit 5 down to bit 0.
- R2: Code slot k of `cmd_codes_i` (bits 6k+5..6k) belongs to device k, where device 0 is nearest the master. The frame for device N_DEV-1 is sent first and the frame for device 0 last. Each transfer has exactly 8*N_DEV rising edges of `sclk_o`.
- R3: `sclk_o` is low while idle. Each high phase lasts HALF_CYC cycles, and each low phase between two rising edges of one transfer lasts HALF_CYC cycles.
- R4: `sdata_o` changes only while `sclk_o` is low. It never changes in a cycle where `sclk_o` is high, so every bit is set up for a full low phase and held for a full high phase.
- R5: The first rising edge of `sclk_o` comes LEAD_CYC+1 cycles after the accepting edge is sampled, with the first bit already on `sdata_o`.
- R6: `le_o` is never high together with `sclk_o`. It rises exactly LEAD_CYC cycles after the final falling edge of `sclk_o`.
- R7: Each transfer produces exactly one `le_o` pulse, and that pulse is exactly LEW_CYC cycles wide.
- R8: `done_o` is high for exactly one cycle, in the first cycle after `le_o` falls.
- R9: `cmd_ready_o` is the inverse of `busy_o`. A command is accepted only while ready is high. `cmd_valid_i` pulsed while busy starts nothing and does not change the frames being sent.
- R10: `cmd_ready_o` returns GAP_CYC+1 cycles after `le_o` falls. With the default 5 ns clock, consecutive `le_o` pulses are therefore separated by at least 630 ns (126 cycles), even when valid is held high.
- R11: After reset, `sclk_o`, `le_o`, `done_o` and `busy_o` are low and `cmd_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Command ready (idle) |
| cmd_codes_i | input | 6*N_DEV | One 6-bit code per device, slot 0 nearest |
| sclk_o | output | 1 | Serial clock to chain |
| sdata_o | output | 1 | Serial data to chain |
| le_o | output | 1 | Latch enable to chain |
| busy_o | output | 1 | Transfer or spacing in progress |
| done_o | output | 1 | One-cycle pulse after latch |

## Verification
Transfers are run with all-zero codes, all-ones codes, a distinct power-of-two code per device and alternating 010101/101010 codes. The all-zero and all-ones patterns show that the pad bits stay zero. The distinct codes expose any swap of device order or bit order. The alternating codes catch a data bit shifted by one clock position. A command pulse during a busy transfer checks that nothing extra is sent. Valid held through two transfers checks the spacing between latch pulses and the hand-over of new codes.

// File: rtl/atten_chain_pkg.sv
package atten_chain_pkg;
  localparam int CODE_W  = 6;
  localparam int PAD_W   = 2;
  localparam int FRAME_W = CODE_W + PAD_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TAIL,
    ST_LATCH,
    ST_DONE,
    ST_GAP
  } seq_state_t;
endpackage

// File: rtl/atten_frame_pack.sv
module atten_frame_pack
  import atten_chain_pkg::*;
#(
  parameter int N_DEV = 4
) (
  input  logic [N_DEV*CODE_W-1:0]  codes_i,
  output logic [N_DEV*FRAME_W-1:0] frame_o
);
  // Slot k sits at frame bits [8k+7:8k]; the MSB end (slot N_DEV-1) leaves first.
  for (genvar k = 0; k < N_DEV; k++) begin : g_slot
    assign frame_o[k*FRAME_W +: FRAME_W] = {{PAD_W{1'b0}}, codes_i[k*CODE_W +: CODE_W]};
  end
endmodule

// File: rtl/atten_phase_timer.sv
module atten_phase_timer #(
  parameter int TW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/atten_bit_shifter.sv
module atten_bit_shifter #(
  parameter int TOT_BITS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [TOT_BITS-1:0] frame_i,
  input  logic                adv_i,
  output logic                sdata_o
);
  logic [TOT_BITS-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sh_q <= '0;
    else if (load_i)  sh_q <= frame_i;
    else if (adv_i)   sh_q <= {sh_q[TOT_BITS-2:0], 1'b0};
  end

  assign sdata_o = sh_q[TOT_BITS-1];
endmodule

// File: rtl/atten_seq_ctrl.sv
module atten_seq_ctrl
  import atten_chain_pkg::*;
#(
  parameter int TOT_BITS = 32,
  parameter int HALF_CYC = 8,
  parameter int LEAD_CYC = 4,
  parameter int LEW_CYC  = 3,
  parameter int GAP_CYC  = 126,
  parameter int TW       = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic          sh_load_o,
  output logic          sh_adv_o,
  output logic          sclk_o,
  output logic          le_o,
  output logic          done_o,
  output logic          busy_o
);
  localparam int BW  = (TOT_BITS > 1) ? $clog2(TOT_BITS) : 1;
  localparam int LRW = $clog2(LEW_CYC + 2);
  localparam int SPW = $clog2(GAP_CYC + 2);

  seq_state_t    state_q, state_d;
  logic [BW-1:0] bits_q, bits_d;
  logic          sclk_q, le_q, done_q, busy_q;

  always_comb begin
    state_d    = state_q;
    bits_d     = bits_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    sh_load_o  = 1'b0;
    sh_adv_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d    = ST_LEAD;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(LEAD_CYC - 1);
        sh_load_o  = 1'b1;
        bits_d     = BW'(TOT_BITS - 1);
      end
      ST_LEAD: if (tmr_zero_i) begin
        state_d    = ST_HIGH;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(HALF_CYC - 1);
      end
      ST_HIGH: if (tmr_zero_i) begin
        tmr_load_o = 1'b1;
        if (bits_q == '0) begin
          state_d   = ST_TAIL;
          tmr_val_o = TW'(LEAD_CYC - 1);
        end else begin
          state_d   = ST_LOW;
          tmr_val_o = TW'(HALF_CYC - 1);
          sh_adv_o  = 1'b1;
          bits_d    = bits_q - 1'b1;
        end
      end
      ST_LOW: if (tmr_zero_i) begin
        state_d    = ST_HIGH;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(HALF_CYC - 1);
      end
      ST_TAIL: if (tmr_zero_i) begin
        state_d    = ST_LATCH;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(LEW_CYC - 1);
      end
      ST_LATCH: if (tmr_zero_i) state_d = ST_DONE;
      ST_DONE: begin
        state_d    = ST_GAP;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(GAP_CYC - 1);
      end
      ST_GAP: if (tmr_zero_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Pin drivers are registered from the next state, so they switch cleanly on the edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bits_q  <= '0;
      sclk_q  <= 1'b0;
      le_q    <= 1'b0;
      done_q  <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bits_q  <= bits_d;
      sclk_q  <= (state_d == ST_HIGH);
      le_q    <= (state_d == ST_LATCH);
      done_q  <= (state_d == ST_DONE);
      busy_q  <= (state_d != ST_IDLE);
    end
  end

  assign sclk_o = sclk_q;
  assign le_o   = le_q;
  assign done_o = done_q;
  assign busy_o = busy_q;

  // Run counters used only by the timing properties below.
  logic [LRW-1:0] le_run_q;
  logic [SPW-1:0] since_le_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      le_run_q   <= '0;
      since_le_q <= SPW'(GAP_CYC + 1);
    end else begin
      if (!le_q)                               le_run_q <= '0;
      else if (le_run_q != LRW'(LEW_CYC + 1))  le_run_q <= le_run_q + 1'b1;
      if (le_q)                                since_le_q <= '0;
      else if (since_le_q != SPW'(GAP_CYC + 1)) since_le_q <= since_le_q + 1'b1;
    end
  end

  AST_LE_APART_FROM_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
    le_q |-> !sclk_q); // R6
  AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!sclk_q && !le_q)); // R3
  AST_DONE_AFTER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(le_q) && !le_q)); // R8
  AST_LATCH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(le_q) |-> (le_run_q == LRW'(LEW_CYC))); // R7
  AST_LATCH_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(le_q) |-> (since_le_q == SPW'(GAP_CYC + 1))); // R10
endmodule

// File: rtl/atten_chain_prog.sv
module atten_chain_prog
  import atten_chain_pkg::*;
#(
  parameter int N_DEV      = 4,
  parameter int SYS_CLK_NS = 5,
  parameter int HALF_CYC   = 8,
  parameter int LEAD_CYC   = 4,
  parameter int LEW_CYC    = 3,
  parameter int GAP_CYC    = 126
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid_i,
  output logic                    cmd_ready_o,
  input  logic [N_DEV*CODE_W-1:0] cmd_codes_i,
  output logic                    sclk_o,
  output logic                    sdata_o,
  output logic                    le_o,
  output logic                    busy_o,
  output logic                    done_o
);
  localparam int TOT_BITS = N_DEV * FRAME_W;
  localparam int MAX_AB   = (HALF_CYC > LEAD_CYC) ? HALF_CYC : LEAD_CYC;
  localparam int MAX_CD   = (LEW_CYC > GAP_CYC) ? LEW_CYC : GAP_CYC;
  localparam int T_MAX    = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int TW       = $clog2(T_MAX + 1);

  // Device timing minimums, in ns, checked against the cycle counts.
  if (N_DEV < 1 || HALF_CYC < 1 || LEAD_CYC < 1 || LEW_CYC < 1 || GAP_CYC < 1 ||
      2 * HALF_CYC * SYS_CLK_NS < 70 || HALF_CYC * SYS_CLK_NS < 15 ||
      LEAD_CYC * SYS_CLK_NS < 15 || LEW_CYC * SYS_CLK_NS < 10 ||
      (GAP_CYC + 1) * SYS_CLK_NS < 630) begin : g_timing_check
    $error("atten_chain_prog: cycle parameters violate serial timing minimums");
  end

  logic                start;
  logic                tmr_load, tmr_zero, sh_load, sh_adv;
  logic [TW-1:0]       tmr_val;
  logic [TOT_BITS-1:0] frame;

  assign cmd_ready_o = ~busy_o;
  assign start       = cmd_valid_i & cmd_ready_o;

  atten_frame_pack #(.N_DEV(N_DEV)) u_pack (
    .codes_i (cmd_codes_i),
    .frame_o (frame)
  );

  atten_phase_timer #(.TW(TW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  atten_bit_shifter #(.TOT_BITS(TOT_BITS)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (sh_load),
    .frame_i (frame),
    .adv_i   (sh_adv),
    .sdata_o (sdata_o)
  );

  atten_seq_ctrl #(
    .TOT_BITS (TOT_BITS),
    .HALF_CYC (HALF_CYC),
    .LEAD_CYC (LEAD_CYC),
    .LEW_CYC  (LEW_CYC),
    .GAP_CYC  (GAP_CYC),
    .TW       (TW)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .tmr_zero_i (tmr_zero),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .sh_load_o  (sh_load),
    .sh_adv_o   (sh_adv),
    .sclk_o     (sclk_o),
    .le_o       (le_o),
    .done_o     (done_o),
    .busy_o     (busy_o)
  );

  AST_DATA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> $stable(sdata_o)); // R4
  AST_ACCEPT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(cmd_valid_i)); // R9
  AST_NO_CLOCK_IN_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    le_o |-> !sclk_o); // R6
endmodule

// File: tb/atten_chain_prog_tb_top.sv
`timescale 1ns/100ps
module atten_chain_prog_tb_top;
  localparam int N    = 4;
  localparam int HALF = 8;
  localparam int LEAD = 4;
  localparam int LEW  = 3;
  localparam int GAP  = 126;
  localparam int TOT  = N * 8;
  localparam int CW   = N * 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [CW-1:0] codes = '0;
  logic ready, sclk, sdata, le, busy, done;

  always #2.5 clk = ~clk;

  atten_chain_prog #(.N_DEV(N), .SYS_CLK_NS(5), .HALF_CYC(HALF), .LEAD_CYC(LEAD),
                     .LEW_CYC(LEW), .GAP_CYC(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(valid), .cmd_ready_o(ready),
    .cmd_codes_i(codes), .sclk_o(sclk), .sdata_o(sdata), .le_o(le),
    .busy_o(busy), .done_o(done));

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  // Port monitor, sampled on the falling system-clock edge.
  int cyc = 0, nrise = 0, rises_in_xfer = 0, n_le = 0, n_done = 0, n_acc = 0;
  int hi_bad = 0, lo_bad = 0, dat_bad = 0, le_sclk = 0;
  int acc_cyc = 0, first_rise = 0, rise_cyc = 0, fall_cyc = 0;
  int le_rise = 0, le_fall = 0, le_w = 0, done_cyc = 0, ready_rise = 0;
  bit cap [0:4095];
  logic p_sclk = 1'b0, p_sdata = 1'b0, p_le = 1'b0, p_ready = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (valid && ready) begin acc_cyc = cyc; n_acc++; rises_in_xfer = 0; end
      if (sclk && !p_sclk) begin
        cap[nrise % 4096] = sdata;
        nrise++;
        if (rises_in_xfer == 0) first_rise = cyc;
        else if (cyc - fall_cyc != HALF) lo_bad++;
        rises_in_xfer++;
        rise_cyc = cyc;
      end
      if (!sclk && p_sclk) begin
        if (cyc - rise_cyc != HALF) hi_bad++;
        fall_cyc = cyc;
      end
      if (sclk && sdata !== p_sdata) dat_bad++;
      if (le && sclk) le_sclk++;
      if (le && !p_le) begin le_rise = cyc; n_le++; end
      if (!le && p_le) begin le_fall = cyc; le_w = cyc - le_rise; end
      if (done) begin n_done++; done_cyc = cyc; end
      if (ready && !p_ready) ready_rise = cyc;
    end
    p_sclk = sclk; p_sdata = sdata; p_le = le; p_ready = ready;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick_mid();
    @(negedge clk); #1;
  endtask

  function automatic bit exp_bit(input logic [CW-1:0] c, input int i);
    int dev = N - 1 - i / 8;
    int b   = 7 - i % 8;
    if (b >= 6) return 1'b0;
    return c[dev*6 + b];
  endfunction

  function automatic logic [CW-1:0] pack4(input int a0, input int a1, input int a2, input int a3);
    return {6'(a3), 6'(a2), 6'(a1), 6'(a0)};
  endfunction

  task automatic check_stream(input logic [CW-1:0] c, input int base, input string tag);
    int mism = 0, pad_bad = 0;
    for (int i = 0; i < TOT; i++) begin
      if (cap[(base + i) % 4096] !== exp_bit(c, i)) mism++;
      if ((i % 8) < 2 && cap[(base + i) % 4096] !== 1'b0) pad_bad++;
    end
    chk(pad_bad == 0, "R1", {tag, " pad bits zero"}, pad_bad, 0);
    chk(mism == 0, "R2", {tag, " stream order/content"}, mism, 0);
  endtask

  // Full transfer with per-transfer timing checks.
  task automatic run_xfer(input logic [CW-1:0] c, input string tag);
    int r0 = nrise, l0 = n_le, d0 = n_done, a0 = n_acc;
    int hb0 = hi_bad, lb0 = lo_bad, db0 = dat_bad, ls0 = le_sclk;
    @(posedge clk); #1;
    valid = 1'b1; codes = c;
    while (n_acc == a0) tick_mid();
    @(posedge clk); #1;
    valid = 1'b0;
    while (n_done == d0) tick_mid();
    while (!ready) tick_mid();
    tick_mid();
    chk(nrise - r0 == TOT, "R2", {tag, " rising edges"}, nrise - r0, TOT);
    check_stream(c, r0, tag);
    chk(hi_bad == hb0 && lo_bad == lb0, "R3", {tag, " phase widths"}, hi_bad - hb0 + lo_bad - lb0, 0);
    chk(dat_bad == db0, "R4", {tag, " data change while high"}, dat_bad - db0, 0);
    chk(first_rise - acc_cyc == LEAD + 1, "R5", {tag, " lead time"}, first_rise - acc_cyc, LEAD + 1);
    chk(le_rise - fall_cyc == LEAD, "R6", {tag, " tail before latch"}, le_rise - fall_cyc, LEAD);
    chk(le_sclk == ls0, "R6", {tag, " latch with clock"}, le_sclk - ls0, 0);
    chk(n_le - l0 == 1, "R7", {tag, " latch pulse count"}, n_le - l0, 1);
    chk(le_w == LEW, "R7", {tag, " latch width"}, le_w, LEW);
    chk(n_done - d0 == 1 && done_cyc == le_fall, "R8", {tag, " done timing"}, done_cyc - le_fall, 0);
    chk(ready_rise - le_fall == GAP + 1, "R10", {tag, " ready after latch"}, ready_rise - le_fall, GAP + 1);
    chk(ready == !busy, "R9", {tag, " ready vs busy"}, ready, !busy);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) tick_mid();
    chk(!sclk && !le && !done && !busy && ready, "R11", "reset outputs",
        {sclk, le, done, busy, ready}, 5'b00001);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (2) tick_mid();
    chk(ready && !busy && !sclk, "R11", "idle after reset", {ready, busy, sclk}, 3'b100);
  endtask

  task automatic t_busy_ignore();
    logic [CW-1:0] a = pack4(6'h11, 6'h22, 6'h33, 6'h0C);
    logic [CW-1:0] b = pack4(6'h3F, 6'h00, 6'h3F, 6'h00);
    int r0 = nrise, l0 = n_le, d0 = n_done, a0 = n_acc;
    @(posedge clk); #1; valid = 1'b1; codes = a;
    while (n_acc == a0) tick_mid();
    @(posedge clk); #1; valid = 1'b0;
    repeat (40) @(posedge clk);
    #1; valid = 1'b1; codes = b;
    repeat (5) @(posedge clk);
    #1; valid = 1'b0; codes = a;
    while (n_done == d0) tick_mid();
    while (!ready) tick_mid();
    repeat (30) tick_mid();
    chk(n_acc - a0 == 1, "R9", "busy pulse accepted", n_acc - a0, 1);
    chk(nrise - r0 == TOT, "R9", "edges with busy pulse", nrise - r0, TOT);
    check_stream(a, r0, "busy-pulse");
    chk(n_le - l0 == 1 && !busy, "R9", "no second transfer", n_le - l0, 1);
  endtask

  task automatic t_back_to_back();
    logic [CW-1:0] a = pack4(6'h01, 6'h02, 6'h03, 6'h04);
    logic [CW-1:0] b = pack4(6'h3E, 6'h3D, 6'h3B, 6'h37);
    int a0 = n_acc, d0 = n_done, first_fall, r1;
    @(posedge clk); #1; valid = 1'b1; codes = a;
    while (n_acc == a0) tick_mid();
    @(posedge clk); #1; codes = b;
    while (n_done == d0) tick_mid();
    first_fall = le_fall;
    r1 = nrise;
    while (n_acc == a0 + 1) tick_mid();
    @(posedge clk); #1; valid = 1'b0;
    while (n_done == d0 + 1) tick_mid();
    while (!ready) tick_mid();
    chk(le_rise - first_fall >= 126, "R10", "latch spacing held valid", le_rise - first_fall, 126);
    chk(ready_rise - le_fall == GAP + 1, "R10", "ready after second latch", ready_rise - le_fall, GAP + 1);
    check_stream(b, r1, "second-of-pair");
  endtask

  initial begin
    t_reset();
    run_xfer('0, "zeros");
    run_xfer({CW{1'b1}}, "ones");
    run_xfer(pack4(6'h01, 6'h04, 6'h10, 6'h20), "distinct");
    run_xfer(pack4(6'h15, 6'h2A, 6'h15, 6'h2A), "alternating");
    t_busy_ignore();
    t_back_to_back();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule